// File: doc/BRIEF.md
# Privilege-Aware Translation Permission Checker

This block sits between a page-table walker and the load/store/fetch path of a processor core. For every access it decides whether address translation applies at all, given the current privilege level, the privilege-override field used for data accesses and the translation mode. When translation is skipped, the block builds an identity page-table entry of its own, refusing any address at or beyond the configured memory size. When translation applies, it takes the entry delivered by the walker.

Permission bits for supervisor and user live in two groups of three bits inside the entry. For a supervisor-context check the supervisor group is moved down onto the user positions by a fixed shift, so one compare against a single required-bit mask covers both privilege levels. The result is either a physical address or a typed access fault that carries the virtual address.

Requests and results each move on a valid/ready handshake, with one register stage between them, so a result appears one cycle after the request is accepted.

Top module: `xlate_perm_check`

## Requirements
- R1: Translation is skipped when `in_vm_mode` is 0 (bare), or when `in_priv` is 3 (machine) and either `in_mprv` is 3 or the access is a fetch; a skipped access ignores `in_pte` entirely.
- R2: A skipped access whose zero-extended address is at or above `in_mem_size` faults; an address of `in_mem_size`-1 does not.
- R3: A skipped in-range access translates to the identity address (`out_addr` equals `in_vaddr`) and is always allowed to fetch, at any privilege.
- R4: A skipped in-range access may also load and store when the mode is bare, or when machine privilege runs with `in_mprv` equal to 3.
- R5: A translated access that passes takes its page number from `in_pte[ADDR_W-1:PG_SHIFT]` and its page offset from `in_vaddr[PG_SHIFT-1:0]`.
- R6: Entry bits are 0 valid, 1 user-read, 2 user-write, 3 user-execute, 4 supervisor-read, 5 supervisor-write, 6 supervisor-execute. The supervisor bits (4..6) are the ones checked when `in_priv` is 1, or when `in_priv` is 3 with `in_mprv` 1 on a non-fetch access; otherwise the user bits (1..3) are checked.
- R7: An entry with bit 0 clear faults whatever its permission bits.
- R8: `in_acc` encoding: 0 load, 1 store, 2 fetch, 3 treated as load; fetch needs execute, store needs write, load needs read, each together with valid.
- R9: `out_cause` encoding: 0 none, 1 instruction fault (any fetch), 2 load fault, 3 store fault; `out_fault` is 1 exactly when the cause is non-zero, and on a fault `out_addr` carries `in_vaddr`.
- R10: A request accepted (`in_valid` and `in_ready` high at a clock edge) appears on the outputs after that edge; while `out_valid` is high and `out_ready` low, outputs hold and `in_ready` is low.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_vaddr | input | ADDR_W | Virtual address of the access |
| in_acc | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| in_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| in_mprv | input | 2 | Privilege used for machine-mode data accesses |
| in_vm_mode | input | 2 | Translation mode, 0 means bare |
| in_mem_size | input | ADDR_W+1 | Size of physical memory in bytes |
| in_pte | input | ADDR_W | Page-table entry from the walker |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed this cycle when valid |
| out_fault | output | 1 | Access faults |
| out_cause | output | 2 | Fault type |
| out_addr | output | ADDR_W | Physical address, or faulting virtual address |

## Verification
The hardest case to reach is the machine-privilege data access with the override field set to supervisor: it neither bypasses nor uses the user bits, and only shows itself when the supplied entry carries supervisor-only or user-only rights. The stimulus pairs such entries with each combination of privilege, override field and access kind, so that a wrong bypass decision or a missing shift turns a pass into a fault or the reverse. A stalled output is held while new, different requests wait on the input, showing that nothing leaks past the register stage.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    // access kinds
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // privilege levels
    localparam logic [1:0] PRV_USER  = 2'd0;
    localparam logic [1:0] PRV_SUPER = 2'd1;
    localparam logic [1:0] PRV_MACH  = 2'd3;

    // translation mode
    localparam logic [1:0] VM_BARE   = 2'd0;

    // fault causes
    localparam logic [1:0] CAUSE_NONE  = 2'd0;
    localparam logic [1:0] CAUSE_INSN  = 2'd1;
    localparam logic [1:0] CAUSE_LOAD  = 2'd2;
    localparam logic [1:0] CAUSE_STORE = 2'd3;

    // entry flag positions; supervisor group mirrors the user group
    localparam int unsigned PB_V  = 0;
    localparam int unsigned PB_UR = 1;
    localparam int unsigned PB_UW = 2;
    localparam int unsigned PB_UX = 3;
    localparam int unsigned PB_SR = 4;
    localparam int unsigned PB_SW = 5;
    localparam int unsigned PB_SX = 6;
    localparam int unsigned FLAG_W    = 7;
    localparam int unsigned SUP_SHIFT = PB_SR - PB_UR;

endpackage

// File: rtl/xpc_mode_decode.sv
module xpc_mode_decode
    import xpc_pkg::*;
(
    input  logic [1:0] acc,
    input  logic [1:0] priv,
    input  logic [1:0] mprv,
    input  logic [1:0] vm_mode,
    output logic       bypass,
    output logic       grant_rw,
    output logic       use_sup
);
    logic is_fetch, vm_bare, priv_m, priv_s, mprv_m, mprv_s;

    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        vm_bare  = (vm_mode == VM_BARE);
        priv_m   = (priv == PRV_MACH);
        priv_s   = (priv == PRV_SUPER);
        mprv_m   = (mprv == PRV_MACH);
        mprv_s   = (mprv == PRV_SUPER);

        bypass   = vm_bare || (priv_m && (mprv_m || is_fetch));
        grant_rw = vm_bare || !(priv_m && !mprv_m);
        use_sup  = priv_s || (priv_m && mprv_s && !is_fetch);
    end
endmodule

// File: rtl/xpc_perm_eval.sv
module xpc_perm_eval
    import xpc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned PG_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        acc,
    input  logic [ADDR_W:0]   mem_size,
    input  logic [ADDR_W-1:0] pte,
    input  logic              bypass,
    input  logic              grant_rw,
    input  logic              use_sup,
    output logic              fault,
    output logic [1:0]        cause,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [FLAG_W-1:0] VALID_BIT = FLAG_W'(1) << PB_V;
    localparam logic [FLAG_W-1:0] PERM_MASK = ~VALID_BIT;

    logic                in_range;
    logic [ADDR_W-1:0]   pseudo_pte;
    logic [ADDR_W-1:0]   eff_pte;
    logic [FLAG_W-1:0]   raw_flags;
    logic [FLAG_W-1:0]   folded;
    logic [FLAG_W-1:0]   have;
    logic [FLAG_W-1:0]   need;
    logic                is_fetch, is_store;

    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);
        in_range = ({1'b0, vaddr} < mem_size);

        // identity entry for accesses that skip translation
        pseudo_pte = '0;
        if (in_range) begin
            pseudo_pte[ADDR_W-1:PG_SHIFT] = vaddr[ADDR_W-1:PG_SHIFT];
            pseudo_pte[PB_V]  = 1'b1;
            pseudo_pte[PB_UX] = 1'b1;
            pseudo_pte[PB_SX] = 1'b1;
            if (grant_rw) begin
                pseudo_pte[PB_UR] = 1'b1;
                pseudo_pte[PB_UW] = 1'b1;
                pseudo_pte[PB_SR] = 1'b1;
                pseudo_pte[PB_SW] = 1'b1;
            end
        end

        eff_pte   = bypass ? pseudo_pte : pte;
        raw_flags = eff_pte[FLAG_W-1:0];

        // fold supervisor group onto user positions, then restore valid
        folded = use_sup ? (raw_flags >> SUP_SHIFT) : raw_flags;
        have   = (folded & PERM_MASK) | (raw_flags & VALID_BIT);

        need = VALID_BIT;
        if (is_fetch)      need[PB_UX] = 1'b1;
        else if (is_store) need[PB_UW] = 1'b1;
        else               need[PB_UR] = 1'b1;

        fault = ((have & need) != need);

        if (!fault)        cause = CAUSE_NONE;
        else if (is_fetch) cause = CAUSE_INSN;
        else if (is_store) cause = CAUSE_STORE;
        else               cause = CAUSE_LOAD;

        addr = fault ? vaddr
                     : {eff_pte[ADDR_W-1:PG_SHIFT], vaddr[PG_SHIFT-1:0]};
    end
endmodule

// File: rtl/xlate_perm_check.sv
module xlate_perm_check
    import xpc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned PG_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_vaddr,
    input  logic [1:0]        in_acc,
    input  logic [1:0]        in_priv,
    input  logic [1:0]        in_mprv,
    input  logic [1:0]        in_vm_mode,
    input  logic [ADDR_W:0]   in_mem_size,
    input  logic [ADDR_W-1:0] in_pte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_fault,
    output logic [1:0]        out_cause,
    output logic [ADDR_W-1:0] out_addr
);
    typedef struct packed {
        logic              vld;
        logic              fault;
        logic [1:0]        cause;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t st_d, st_q;

    logic              bypass, grant_rw, use_sup;
    logic              eval_fault;
    logic [1:0]        eval_cause;
    logic [ADDR_W-1:0] eval_addr;

    xpc_mode_decode u_decode (
        .acc      (in_acc),
        .priv     (in_priv),
        .mprv     (in_mprv),
        .vm_mode  (in_vm_mode),
        .bypass   (bypass),
        .grant_rw (grant_rw),
        .use_sup  (use_sup)
    );

    xpc_perm_eval #(
        .ADDR_W   (ADDR_W),
        .PG_SHIFT (PG_SHIFT)
    ) u_eval (
        .vaddr    (in_vaddr),
        .acc      (in_acc),
        .mem_size (in_mem_size),
        .pte      (in_pte),
        .bypass   (bypass),
        .grant_rw (grant_rw),
        .use_sup  (use_sup),
        .fault    (eval_fault),
        .cause    (eval_cause),
        .addr     (eval_addr)
    );

    assign in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_ready) begin
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.fault = eval_fault;
                st_d.cause = eval_cause;
                st_d.addr  = eval_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_fault = st_q.fault;
    assign out_cause = st_q.cause;
    assign out_addr  = st_q.addr;

    // R10: stalled result stays put
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_cause) && $stable(out_fault));

    // R10: accepted request shows up next cycle
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R9: fault flag agrees with cause
    a_r9_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault == (out_cause != CAUSE_NONE)));

    // R2: out-of-range bypassed access must fault
    a_r2_oob_faults: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && bypass && ({1'b0, in_vaddr} >= in_mem_size) |-> eval_fault);

    // R7: invalid walker entry must fault on a translated access
    a_r7_invalid_faults: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !bypass && !in_pte[PB_V] |-> eval_fault);

    // R8: a faulting fetch reports an instruction fault
    a_r8_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && eval_fault && (in_acc == ACC_FETCH) |-> eval_cause == CAUSE_INSN);
endmodule

// File: tb/xlate_perm_check_tb.sv
module xlate_perm_check_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_vaddr = '0;
    logic [1:0]    in_acc = '0;
    logic [1:0]    in_priv = '0;
    logic [1:0]    in_mprv = '0;
    logic [1:0]    in_vm_mode = '0;
    logic [AW:0]   in_mem_size = '0;
    logic [AW-1:0] in_pte = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_fault;
    logic [1:0]    out_cause;
    logic [AW-1:0] out_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [32:0] FULL = 33'h1_0000_0000;
    // entry flags: V=1 UR=2 UW=4 UX=8 SR=10 SW=20 SX=40

    always #10 clk = ~clk;

    xlate_perm_check u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_vaddr(in_vaddr), .in_acc(in_acc), .in_priv(in_priv), .in_mprv(in_mprv),
        .in_vm_mode(in_vm_mode), .in_mem_size(in_mem_size), .in_pte(in_pte),
        .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
        .out_cause(out_cause), .out_addr(out_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input [1:0] acc, input [1:0] prv, input [1:0] mprv, input [1:0] vm,
                         input [31:0] va, input [31:0] pte, input [32:0] msz);
        in_acc = acc; in_priv = prv; in_mprv = mprv; in_vm_mode = vm;
        in_vaddr = va; in_pte = pte; in_mem_size = msz;
    endtask

    task automatic xact(input string req, input [1:0] acc, input [1:0] prv, input [1:0] mprv,
                        input [1:0] vm, input [31:0] va, input [31:0] pte, input [32:0] msz,
                        input [1:0] exp_cause, input [31:0] exp_addr);
        @(negedge clk);
        drive(acc, prv, mprv, vm, va, pte, msz);
        in_valid = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " fault"}, 64'(out_fault), 64'(exp_cause != 2'd0));
        chk({req, " cause"}, 64'(out_cause), 64'(exp_cause));
        chk({req, " addr"},  64'(out_addr),  64'(exp_addr));
    endtask

    task automatic t_reset;
        chk("R11 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R11 in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_bypass;
        // R1/R3/R4: walker entry is zero, bypass must ignore it
        xact("R1 R4 bare user load",    2'd0, 2'd0, 2'd0, 2'd0, 32'h0000_1234, 32'h0, FULL, 2'd0, 32'h0000_1234);
        xact("R1 R4 bare user store",   2'd1, 2'd0, 2'd0, 2'd0, 32'h0000_5678, 32'h0, FULL, 2'd0, 32'h0000_5678);
        xact("R1 R3 bare super fetch",  2'd2, 2'd1, 2'd0, 2'd0, 32'hABCD_0010, 32'h0, FULL, 2'd0, 32'hABCD_0010);
        xact("R1 R4 mach mprvM load",   2'd0, 2'd3, 2'd3, 2'd1, 32'h1357_9BDF, 32'h0, FULL, 2'd0, 32'h1357_9BDF);
        xact("R1 R4 mach mprvM store",  2'd1, 2'd3, 2'd3, 2'd1, 32'h2468_0ACE, 32'h0, FULL, 2'd0, 32'h2468_0ACE);
        xact("R1 R3 mach mprvU fetch",  2'd2, 2'd3, 2'd0, 2'd1, 32'h0040_0100, 32'h0, FULL, 2'd0, 32'h0040_0100);
        xact("R1 R3 mach mprvS fetch",  2'd2, 2'd3, 2'd1, 2'd1, 32'h0040_0200, 32'h0, FULL, 2'd0, 32'h0040_0200);
    endtask

    task automatic t_bound;
        xact("R2 last byte ok",      2'd0, 2'd0, 2'd0, 2'd0, 32'h0000_FFFF, 32'h0, 33'h1_0000, 2'd0, 32'h0000_FFFF);
        xact("R2 load at size",      2'd0, 2'd0, 2'd0, 2'd0, 32'h0001_0000, 32'h0, 33'h1_0000, 2'd2, 32'h0001_0000);
        xact("R2 fetch beyond",      2'd2, 2'd3, 2'd0, 2'd1, 32'h0002_0000, 32'h0, 33'h1_0000, 2'd1, 32'h0002_0000);
        xact("R2 store beyond",      2'd1, 2'd3, 2'd3, 2'd1, 32'h8000_0000, 32'h0, 33'h1_0000, 2'd3, 32'h8000_0000);
    endtask

    task automatic t_translate;
        xact("R5 user load mapped",  2'd0, 2'd0, 2'd0, 2'd1, 32'h5678_9123, 32'h0ABC_D003, FULL, 2'd0, 32'h0ABC_D123);
        xact("R5 user fetch mapped", 2'd2, 2'd0, 2'd0, 2'd1, 32'h0000_2FFC, 32'h7777_7009, FULL, 2'd0, 32'h7777_7FFC);
    endtask

    task automatic t_shift;
        xact("R6 super load S-only",    2'd0, 2'd1, 2'd0, 2'd1, 32'h1000_0444, 32'h0012_3011, FULL, 2'd0, 32'h0012_3444);
        xact("R6 user load S-only",     2'd0, 2'd0, 2'd0, 2'd1, 32'h1000_0444, 32'h0012_3011, FULL, 2'd2, 32'h1000_0444);
        xact("R6 super load U-only",    2'd0, 2'd1, 2'd0, 2'd1, 32'h1000_0444, 32'h0012_3003, FULL, 2'd2, 32'h1000_0444);
        xact("R6 mach mprvS load S",    2'd0, 2'd3, 2'd1, 2'd1, 32'h2000_0010, 32'h0045_6011, FULL, 2'd0, 32'h0045_6010);
        xact("R6 mach mprvS store S",   2'd1, 2'd3, 2'd1, 2'd1, 32'h2000_0020, 32'h0045_6021, FULL, 2'd0, 32'h0045_6020);
        xact("R6 mach mprvS load U",    2'd0, 2'd3, 2'd1, 2'd1, 32'h2000_0030, 32'h0045_6003, FULL, 2'd2, 32'h2000_0030);
        xact("R6 mach mprvU load U",    2'd0, 2'd3, 2'd0, 2'd1, 32'h2000_0040, 32'h0045_6003, FULL, 2'd0, 32'h0045_6040);
        xact("R6 mach mprvU load S",    2'd0, 2'd3, 2'd0, 2'd1, 32'h2000_0050, 32'h0045_6011, FULL, 2'd2, 32'h2000_0050);
        xact("R6 super fetch SX",       2'd2, 2'd1, 2'd0, 2'd1, 32'h3000_0060, 32'h0099_9041, FULL, 2'd0, 32'h0099_9060);
    endtask

    task automatic t_valid;
        xact("R7 invalid load",  2'd0, 2'd0, 2'd0, 2'd1, 32'h4000_0001, 32'h0011_107E, FULL, 2'd2, 32'h4000_0001);
        xact("R7 invalid fetch", 2'd2, 2'd1, 2'd0, 2'd1, 32'h4000_0002, 32'h0011_107E, FULL, 2'd1, 32'h4000_0002);
    endtask

    task automatic t_kind;
        xact("R8 R9 store on read-only", 2'd1, 2'd0, 2'd0, 2'd1, 32'h5000_0100, 32'h0022_2003, FULL, 2'd3, 32'h5000_0100);
        xact("R8 R9 fetch on read-only", 2'd2, 2'd0, 2'd0, 2'd1, 32'h5000_0104, 32'h0022_2003, FULL, 2'd1, 32'h5000_0104);
        xact("R8 code3 as load",         2'd3, 2'd0, 2'd0, 2'd1, 32'h5000_0108, 32'h0022_2003, FULL, 2'd0, 32'h0022_2108);
        xact("R8 store on write-only",   2'd1, 2'd0, 2'd0, 2'd1, 32'h5000_010C, 32'h0022_2005, FULL, 2'd0, 32'h0022_210C);
        xact("R8 R9 load on write-only", 2'd0, 2'd0, 2'd0, 2'd1, 32'h5000_0110, 32'h0022_2005, FULL, 2'd2, 32'h5000_0110);
        xact("R8 R9 code3 on write-only",2'd3, 2'd0, 2'd0, 2'd1, 32'h5000_0114, 32'h0022_2005, FULL, 2'd2, 32'h5000_0114);
    endtask

    task automatic t_stall;
        @(negedge clk);
        out_ready = 1'b0;
        drive(2'd0, 2'd0, 2'd0, 2'd0, 32'h0000_0AAA, 32'h0, FULL);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R10 first result valid", 64'(out_valid), 64'd1);
        chk("R10 first result addr", 64'(out_addr), 64'h0000_0AAA);
        chk("R10 in_ready low in stall", 64'(in_ready), 64'd0);
        drive(2'd1, 2'd0, 2'd0, 2'd0, 32'h0000_0BBB, 32'h0, FULL);
        @(negedge clk);
        @(negedge clk);
        chk("R10 held addr", 64'(out_addr), 64'h0000_0AAA);
        chk("R10 held valid", 64'(out_valid), 64'd1);
        chk("R10 in_ready still low", 64'(in_ready), 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R10 second result valid", 64'(out_valid), 64'd1);
        chk("R10 second result addr", 64'(out_addr), 64'h0000_0BBB);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10 drained", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_bypass();
        t_bound();
        t_translate();
        t_shift();
        t_valid();
        t_kind();
        t_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule